// File: doc/BRIEF.md
# Dual-Accumulator Multiply/ALU Datapath

This block is the arithmetic core of a signal-processing datapath. It holds two 36-bit accumulators, a 32-bit product register and four condition flags. The contents of the x and y operand registers come in on 16-bit inputs. The logic that loads x and y lives elsewhere. Each issued instruction carries a 4-bit operation code, a source select and a destination select. In one clock the block does a multiply, an add, a subtract, a bitwise operation or a move. It writes the result into the chosen accumulator and updates the flags from the value it computed.

The product register behaves as a single pipeline stage. Several codes move or accumulate the product that was already held, and in the same clock the register captures the new signed x*y. The product is sign-extended to accumulator width and is never shifted. The accumulator that is not the current destination is presented on a separate output, so that a neighbouring move unit can read it or exchange it in parallel.

Top module: `mac_alu`

## Requirements
- R1: While rst_n is low, and after it is released, acc0, acc1, prod and all four flags read zero.
- R2: src_sel=0 makes acc0 the source and src_sel=1 makes acc1 the source. dst_sel=0 makes acc0 the destination, and dst_sel=1 makes acc1 the destination. alt_acc always shows the accumulator that the current dst_sel does not pick.
- R3: Codes 4'b0000 (dest = old p), 4'b0001 (dest = src + old p), 4'b0011 (dest = src − old p) and 4'b0010 (no accumulator write) all load prod with the 32-bit signed product of x_opnd and y_opnd at the same clock edge. The accumulator always uses the product that was held before that edge.
- R4: Codes 4'b0100 (dest = p), 4'b0101 (dest = src + p) and 4'b0111 (dest = src − p) use p sign-extended to 36 bits and leave prod unchanged.
- R5: Codes 4'b1100 (dest = y), 4'b1101 (dest = src + y) and 4'b1111 (dest = src − y) use y_opnd sign-extended to 36 bits.
- R6: Codes 4'b1000 (OR), 4'b1001 (XOR) and 4'b1110 (AND) combine the source with the sign-extended y and write the destination.
- R7: Codes 4'b1010 (src AND y) and 4'b1011 (src − y) update the flags only. Neither accumulator changes.
- R8: Code 4'b0110, and any cycle with issue low, leave the accumulators, prod and the flags unchanged.
- R9: flag_neg takes bit 35 of the computed value. flag_zero is set when all 36 bits of that value are zero.
- R10: On an add, flag_carry is the carry out of bit 35. On a subtract, flag_carry is the borrow, which is 1 when the source is unsigned-less than the subtrahend. flag_ovf flags signed overflow at 36 bits for both adds and subtracts.
- R11: Moves and bitwise operations clear flag_ovf and flag_carry. Code 4'b0010 leaves all flags unchanged.
- R12: An instruction never changes the accumulator that is not its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue | input | 1 | An instruction is executed this cycle |
| func | input | 4 | Operation code |
| src_sel | input | 1 | Source accumulator select |
| dst_sel | input | 1 | Destination accumulator select |
| x_opnd | input | 16 | x register value, two's complement |
| y_opnd | input | 16 | y register value, two's complement |
| acc0 | output | 36 | Accumulator 0 |
| acc1 | output | 36 | Accumulator 1 |
| prod | output | 32 | Product register |
| alt_acc | output | 36 | Accumulator not selected as destination |
| flag_neg | output | 1 | Negative flag |
| flag_zero | output | 1 | Zero flag |
| flag_ovf | output | 1 | Signed overflow flag |
| flag_carry | output | 1 | Carry / borrow flag |

## Verification
Two things can happen in the same cycle: the product register is read through an accumulator move or accumulate, and it is written with a new x*y. The bench provokes this with runs of back-to-back codes 0000, 0001 and 0011 in which x and y change on every cycle. It also runs a directed chain of 33 accumulations of the largest product, which pushes the accumulator through signed overflow. A bench model keeps the previously held product apart from the newly captured one. Each result is judged against that model, so an accumulator that picks up the new product, or a product that fails to advance, shows up as a miscompare. Cases where the source and destination are the same accumulator are mixed in at random.

// File: rtl/mac_alu_pkg.sv
// Package mac_alu_pkg
// Shared operation codes, decoded control word and flag record for the
// multiply/ALU datapath. Assumes a 4-bit operation code.
package mac_alu_pkg;

    typedef enum logic [3:0] {
        OP_MOVP_MUL = 4'b0000,
        OP_ADDP_MUL = 4'b0001,
        OP_MUL_ONLY = 4'b0010,
        OP_SUBP_MUL = 4'b0011,
        OP_MOVP     = 4'b0100,
        OP_ADDP     = 4'b0101,
        OP_NOP      = 4'b0110,
        OP_SUBP     = 4'b0111,
        OP_ORY      = 4'b1000,
        OP_XORY     = 4'b1001,
        OP_TSTAND   = 4'b1010,
        OP_CMPY     = 4'b1011,
        OP_MOVY     = 4'b1100,
        OP_ADDY     = 4'b1101,
        OP_ANDY     = 4'b1110,
        OP_SUBY     = 4'b1111
    } mac_op_e;

    typedef enum logic [2:0] {
        K_PASS = 3'd0,
        K_ADD  = 3'd1,
        K_SUB  = 3'd2,
        K_OR   = 3'd3,
        K_XOR  = 3'd4,
        K_AND  = 3'd5
    } alu_kind_e;

    typedef enum logic {
        OPND_P = 1'b0,
        OPND_Y = 1'b1
    } opnd_sel_e;

    typedef struct packed {
        alu_kind_e kind;
        opnd_sel_e opnd;
        logic      wr_acc;
        logic      wr_flags;
        logic      ld_prod;
    } mac_ctrl_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } mac_flags_t;

endpackage

// File: rtl/mac_op_decode.sv
// Module mac_op_decode
// Turns the operation code plus the issue strobe into a control word.
// Assumes that a code which is not issued behaves exactly like the nop code.
module mac_op_decode
    import mac_alu_pkg::*;
(
    input  logic       issue,
    input  logic [3:0] func,
    output mac_ctrl_t  ctrl
);

    // Purpose: map each operation code to its kind, operand and write enables.
    always_comb begin
        ctrl = '{kind: K_PASS, opnd: OPND_P, wr_acc: 1'b0,
                 wr_flags: 1'b0, ld_prod: 1'b0};
        if (issue) begin
            unique case (mac_op_e'(func))
                OP_MOVP_MUL: ctrl = '{K_PASS, OPND_P, 1'b1, 1'b1, 1'b1};
                OP_ADDP_MUL: ctrl = '{K_ADD,  OPND_P, 1'b1, 1'b1, 1'b1};
                OP_MUL_ONLY: ctrl = '{K_PASS, OPND_P, 1'b0, 1'b0, 1'b1};
                OP_SUBP_MUL: ctrl = '{K_SUB,  OPND_P, 1'b1, 1'b1, 1'b1};
                OP_MOVP:     ctrl = '{K_PASS, OPND_P, 1'b1, 1'b1, 1'b0};
                OP_ADDP:     ctrl = '{K_ADD,  OPND_P, 1'b1, 1'b1, 1'b0};
                OP_NOP:      ctrl = '{K_PASS, OPND_P, 1'b0, 1'b0, 1'b0};
                OP_SUBP:     ctrl = '{K_SUB,  OPND_P, 1'b1, 1'b1, 1'b0};
                OP_ORY:      ctrl = '{K_OR,   OPND_Y, 1'b1, 1'b1, 1'b0};
                OP_XORY:     ctrl = '{K_XOR,  OPND_Y, 1'b1, 1'b1, 1'b0};
                OP_TSTAND:   ctrl = '{K_AND,  OPND_Y, 1'b0, 1'b1, 1'b0};
                OP_CMPY:     ctrl = '{K_SUB,  OPND_Y, 1'b0, 1'b1, 1'b0};
                OP_MOVY:     ctrl = '{K_PASS, OPND_Y, 1'b1, 1'b1, 1'b0};
                OP_ADDY:     ctrl = '{K_ADD,  OPND_Y, 1'b1, 1'b1, 1'b0};
                OP_ANDY:     ctrl = '{K_AND,  OPND_Y, 1'b1, 1'b1, 1'b0};
                OP_SUBY:     ctrl = '{K_SUB,  OPND_Y, 1'b1, 1'b1, 1'b0};
                default:     ctrl = '{K_PASS, OPND_P, 1'b0, 1'b0, 1'b0};
            endcase
        end
    end

endmodule

// File: rtl/mac_alu_core.sv
// Module mac_alu_core
// Combinational arithmetic/logic stage. It sign-extends the product and y to
// accumulator width, applies the selected operation to the source accumulator
// and derives the next flags. Assumes ACC_W > PROD_W >= DATA_W.
module mac_alu_core
    import mac_alu_pkg::*;
#(
    parameter int ACC_W  = 36,
    parameter int DATA_W = 16,
    parameter int PROD_W = 32
) (
    input  mac_ctrl_t           ctrl,
    input  logic [ACC_W-1:0]    src_val,
    input  logic [PROD_W-1:0]   prod_val,
    input  logic [DATA_W-1:0]   y_val,
    output logic [ACC_W-1:0]    result,
    output mac_flags_t          flags_out
);

    localparam int PEXT = ACC_W - PROD_W;
    localparam int YEXT = ACC_W - DATA_W;
    localparam int MSB  = ACC_W - 1;

    logic [ACC_W-1:0] p_ext;
    logic [ACC_W-1:0] y_ext;
    logic [ACC_W-1:0] opb;
    logic [ACC_W:0]   wide;
    logic             ovf;
    logic             cry;

    // Purpose: widen both candidate operands with their sign bits.
    always_comb begin
        p_ext = {{PEXT{prod_val[PROD_W-1]}}, prod_val};
        y_ext = {{YEXT{y_val[DATA_W-1]}}, y_val};
        opb   = (ctrl.opnd == OPND_Y) ? y_ext : p_ext;
    end

    // Purpose: compute the result together with its carry and overflow terms.
    always_comb begin
        wide   = '0;
        result = '0;
        ovf    = 1'b0;
        cry    = 1'b0;
        unique case (ctrl.kind)
            K_ADD: begin
                wide   = {1'b0, src_val} + {1'b0, opb};
                result = wide[ACC_W-1:0];
                cry    = wide[ACC_W];
                ovf    = (src_val[MSB] == opb[MSB]) && (result[MSB] != src_val[MSB]);
            end
            K_SUB: begin
                wide   = {1'b0, src_val} + {1'b0, ~opb} + (ACC_W+1)'(1);
                result = wide[ACC_W-1:0];
                cry    = ~wide[ACC_W];
                ovf    = (src_val[MSB] != opb[MSB]) && (result[MSB] != src_val[MSB]);
            end
            K_OR:    result = src_val | opb;
            K_XOR:   result = src_val ^ opb;
            K_AND:   result = src_val & opb;
            default: result = opb;
        endcase
    end

    // Purpose: pack the flag record from the computed value.
    always_comb begin
        flags_out.n = result[MSB];
        flags_out.z = (result == '0);
        flags_out.v = ovf;
        flags_out.c = cry;
    end

endmodule

// File: rtl/mac_acc_bank.sv
// Module mac_acc_bank
// Register file of accumulators. Exactly one entry, chosen by wr_idx, is
// written when wr_en is high. Assumes a synchronous active-low reset.
module mac_acc_bank #(
    parameter int ACC_W   = 36,
    parameter int NUM_ACC = 2,
    localparam int IDX_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [ACC_W-1:0]                wr_data,
    output logic [NUM_ACC-1:0][ACC_W-1:0]   acc_q
);

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        // Purpose: hold one accumulator and load it when it is the target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                acc_q[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/mac_prod_flags.sv
// Module mac_prod_flags
// Product register and condition flags. The product register captures the
// signed x*y when ld_prod is high, and it is read in the same cycle it is
// loaded, so it acts as a one-stage pipeline. Assumes an active-low sync reset.
module mac_prod_flags
    import mac_alu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PROD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_prod,
    input  logic                wr_flags,
    input  logic [DATA_W-1:0]   x_val,
    input  logic [DATA_W-1:0]   y_val,
    input  mac_flags_t          flags_in,
    output logic [PROD_W-1:0]   prod_q,
    output mac_flags_t          flags_q
);

    logic signed [PROD_W-1:0] xs;
    logic signed [PROD_W-1:0] ys;
    logic signed [PROD_W-1:0] prod_next;

    // Purpose: form the signed product at full product width.
    always_comb begin
        xs        = PROD_W'($signed(x_val));
        ys        = PROD_W'($signed(y_val));
        prod_next = xs * ys;
    end

    // Purpose: product register, loaded by the multiplying codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else if (ld_prod) begin
            prod_q <= prod_next;
        end
    end

    // Purpose: flag register, loaded when an operation produces a value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (wr_flags) begin
            flags_q <= flags_in;
        end
    end

endmodule

// File: rtl/mac_alu.sv
// Module mac_alu
// Top of the multiply/ALU datapath: decode, source mux, arithmetic stage,
// accumulator bank, product register and flags. The accumulator opposite the
// destination is exported for a parallel move unit. Assumes the x and y
// register contents arrive stable for the whole issue cycle.
module mac_alu
    import mac_alu_pkg::*;
#(
    parameter int ACC_W  = 36,
    parameter int DATA_W = 16,
    localparam int PROD_W = 2 * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue,
    input  logic [3:0]          func,
    input  logic                src_sel,
    input  logic                dst_sel,
    input  logic [DATA_W-1:0]   x_opnd,
    input  logic [DATA_W-1:0]   y_opnd,
    output logic [ACC_W-1:0]    acc0,
    output logic [ACC_W-1:0]    acc1,
    output logic [PROD_W-1:0]   prod,
    output logic [ACC_W-1:0]    alt_acc,
    output logic                flag_neg,
    output logic                flag_zero,
    output logic                flag_ovf,
    output logic                flag_carry
);

    localparam int NUM_ACC = 2;

    mac_ctrl_t                        ctrl;
    logic [NUM_ACC-1:0][ACC_W-1:0]    acc_q;
    logic [ACC_W-1:0]                 src_val;
    logic [ACC_W-1:0]                 result;
    logic [PROD_W-1:0]                prod_q;
    mac_flags_t                       flags_next;
    mac_flags_t                       flags_q;

    mac_op_decode u_dec (
        .issue (issue),
        .func  (func),
        .ctrl  (ctrl)
    );

    // Purpose: pick the source accumulator and the one opposite the destination.
    always_comb begin
        src_val = acc_q[src_sel];
        alt_acc = acc_q[~dst_sel];
    end

    mac_alu_core #(
        .ACC_W  (ACC_W),
        .DATA_W (DATA_W),
        .PROD_W (PROD_W)
    ) u_core (
        .ctrl      (ctrl),
        .src_val   (src_val),
        .prod_val  (prod_q),
        .y_val     (y_opnd),
        .result    (result),
        .flags_out (flags_next)
    );

    mac_acc_bank #(
        .ACC_W   (ACC_W),
        .NUM_ACC (NUM_ACC)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl.wr_acc),
        .wr_idx  (dst_sel),
        .wr_data (result),
        .acc_q   (acc_q)
    );

    mac_prod_flags #(
        .DATA_W (DATA_W),
        .PROD_W (PROD_W)
    ) u_pf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_prod  (ctrl.ld_prod),
        .wr_flags (ctrl.wr_flags),
        .x_val    (x_opnd),
        .y_val    (y_opnd),
        .flags_in (flags_next),
        .prod_q   (prod_q),
        .flags_q  (flags_q)
    );

    // Purpose: drive the register contents onto the output ports.
    always_comb begin
        acc0       = acc_q[0];
        acc1       = acc_q[1];
        prod       = prod_q;
        flag_neg   = flags_q.n;
        flag_zero  = flags_q.z;
        flag_ovf   = flags_q.v;
        flag_carry = flags_q.c;
    end

endmodule

// File: rtl/mac_alu_chk.sv
// Module mac_alu_chk
// Temporal checks on the ports of mac_alu, attached by bind.
// Assumes rst_n is held low from time zero until the first edges.
module mac_alu_chk #(
    parameter int ACC_W  = 36,
    parameter int DATA_W = 16,
    parameter int PROD_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                issue,
    input logic [3:0]          func,
    input logic                dst_sel,
    input logic [DATA_W-1:0]   x_opnd,
    input logic [DATA_W-1:0]   y_opnd,
    input logic [ACC_W-1:0]    acc0,
    input logic [ACC_W-1:0]    acc1,
    input logic [PROD_W-1:0]   prod,
    input logic                flag_neg,
    input logic                flag_zero,
    input logic                flag_ovf,
    input logic                flag_carry
);

    logic signed [PROD_W-1:0] exp_prod;
    logic [ACC_W-1:0]         prod_ext;
    logic [ACC_W-1:0]         dest_now;
    logic                     hold_op;
    logic                     logic_op;
    logic                     acc_wr_op;

    // Purpose: reference product, widened product, current destination view.
    always_comb begin
        exp_prod  = PROD_W'($signed(x_opnd)) * PROD_W'($signed(y_opnd));
        prod_ext  = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
        dest_now  = dst_sel ? acc1 : acc0;
        hold_op   = !issue || (func == 4'b0110);
        logic_op  = issue && (func inside {4'b1000, 4'b1001, 4'b1010, 4'b1110,
                                           4'b0000, 4'b0100, 4'b1100});
        acc_wr_op = issue && !(func inside {4'b0010, 4'b0110, 4'b1010, 4'b1011});
    end

    AST_HOLD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        hold_op |=> $stable(acc0) && $stable(acc1) && $stable(prod) &&
                    $stable({flag_neg, flag_zero, flag_ovf, flag_carry})); // R8

    AST_PROD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && func[3:2] == 2'b00) |=> (prod == $past(exp_prod))); // R3

    AST_OLD_PROD_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && func == 4'b0000) |=>
            ((($past(dst_sel)) ? acc1 : acc0) == $past(prod_ext))); // R3

    AST_FLAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (func == 4'b1010 || func == 4'b1011)) |=>
            $stable(acc0) && $stable(acc1) && $stable(prod)); // R7

    AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        logic_op |=> (!flag_ovf && !flag_carry)); // R11

    AST_MUL_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && func == 4'b0010) |=>
            $stable({flag_neg, flag_zero, flag_ovf, flag_carry})); // R11

    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr_op |=> (flag_zero == ((($past(dst_sel)) ? acc1 : acc0) == '0))); // R9

    AST_NEG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr_op |=> (flag_neg == (($past(dst_sel)) ? acc1[ACC_W-1] : acc0[ACC_W-1]))); // R9

    AST_OTHER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (($past(dst_sel)) ? $stable(acc0) : $stable(acc1))); // R12

    // Purpose: keep dest_now referenced for readability of waveforms only.
    always_comb begin
        AST_DEST_KNOWN: assert (!rst_n || !$isunknown(dest_now)); // R1
    end

endmodule

bind mac_alu mac_alu_chk #(
    .ACC_W  (ACC_W),
    .DATA_W (DATA_W),
    .PROD_W (PROD_W)
) u_mac_alu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .func       (func),
    .dst_sel    (dst_sel),
    .x_opnd     (x_opnd),
    .y_opnd     (y_opnd),
    .acc0       (acc0),
    .acc1       (acc1),
    .prod       (prod),
    .flag_neg   (flag_neg),
    .flag_zero  (flag_zero),
    .flag_ovf   (flag_ovf),
    .flag_carry (flag_carry)
);

// File: tb/mac_alu_bench.sv
// Bench for mac_alu: seeded random instructions plus directed corner cases,
// compared against a behavioural model kept in the bench.
module mac_alu_bench;

    logic        clk;
    logic        rst_n;
    logic        issue;
    logic [3:0]  func;
    logic        src_sel;
    logic        dst_sel;
    logic [15:0] x_opnd;
    logic [15:0] y_opnd;
    logic [35:0] acc0;
    logic [35:0] acc1;
    logic [31:0] prod;
    logic [35:0] alt_acc;
    logic        flag_neg;
    logic        flag_zero;
    logic        flag_ovf;
    logic        flag_carry;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [35:0] m_a0, m_a1;
    logic [31:0] m_p;
    logic [3:0]  m_fl;

    mac_alu u_mac_alu (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (issue),
        .func       (func),
        .src_sel    (src_sel),
        .dst_sel    (dst_sel),
        .x_opnd     (x_opnd),
        .y_opnd     (y_opnd),
        .acc0       (acc0),
        .acc1       (acc1),
        .prod       (prod),
        .alt_acc    (alt_acc),
        .flag_neg   (flag_neg),
        .flag_zero  (flag_zero),
        .flag_ovf   (flag_ovf),
        .flag_carry (flag_carry)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic iss, input logic [3:0] f);
        if (!iss || f == 4'b0110) return "R8";
        case (f)
            4'b0000, 4'b0001, 4'b0010, 4'b0011: return "R3";
            4'b0100, 4'b0101, 4'b0111:          return "R4";
            4'b1100, 4'b1101, 4'b1111:          return "R5";
            4'b1000, 4'b1001, 4'b1110:          return "R6";
            default:                            return "R7";
        endcase
    endfunction

    // Model: advance bench state by one instruction.
    task automatic model(input logic iss, input logic [3:0] f, input logic s,
                         input logic d, input logic [15:0] x, input logic [15:0] y);
        logic [35:0] a, b, r;
        logic [36:0] w;
        logic signed [31:0] pr;
        logic nv, nc, wr;
        if (!iss || f == 4'b0110) return;
        a  = s ? m_a1 : m_a0;
        b  = f[3] ? {{20{y[15]}}, y} : {{4{m_p[31]}}, m_p};
        nv = 1'b0;
        nc = 1'b0;
        case (f)
            4'b0001, 4'b0101, 4'b1101: begin
                w = {1'b0, a} + {1'b0, b}; r = w[35:0]; nc = w[36];
                nv = (a[35] == b[35]) && (r[35] != a[35]);
            end
            4'b0011, 4'b0111, 4'b1111, 4'b1011: begin
                w = {1'b0, a} - {1'b0, b}; r = w[35:0]; nc = w[36];
                nv = (a[35] != b[35]) && (r[35] != a[35]);
            end
            4'b1000:          r = a | b;
            4'b1001:          r = a ^ b;
            4'b1010, 4'b1110: r = a & b;
            default:          r = b;
        endcase
        wr = !(f inside {4'b0010, 4'b1010, 4'b1011});
        if (f != 4'b0010) m_fl = {r[35], (r == 36'd0), nv, nc};
        if (wr) begin
            if (d) m_a1 = r;
            else   m_a0 = r;
        end
        if (f[3:2] == 2'b00) begin
            pr  = $signed(x) * $signed(y);
            m_p = pr;
        end
    endtask

    // Apply one instruction at a negedge and compare one cycle later.
    task automatic apply(input logic iss, input logic [3:0] f, input logic s,
                         input logic d, input logic [15:0] x, input logic [15:0] y);
        string t;
        issue = iss; func = f; src_sel = s; dst_sel = d; x_opnd = x; y_opnd = y;
        #1;
        check(alt_acc == (d ? m_a0 : m_a1), "R2", 64'(alt_acc), 64'(d ? m_a0 : m_a1));
        t = tag_of(iss, f);
        model(iss, f, s, d, x, y);
        @(negedge clk);
        check(d ? (acc1 == m_a1) : (acc0 == m_a0), t,
              64'(d ? acc1 : acc0), 64'(d ? m_a1 : m_a0));
        check(d ? (acc0 == m_a0) : (acc1 == m_a1), "R12",
              64'(d ? acc0 : acc1), 64'(d ? m_a0 : m_a1));
        check(prod == m_p, t, 64'(prod), 64'(m_p));
        check({flag_neg, flag_zero} == m_fl[3:2], "R9",
              64'({flag_neg, flag_zero}), 64'(m_fl[3:2]));
        check({flag_ovf, flag_carry} == m_fl[1:0],
              (f[3] && f != 4'b1011 && f != 4'b1101 && f != 4'b1111) ? "R11" : "R10",
              64'({flag_ovf, flag_carry}), 64'(m_fl[1:0]));
    endtask

    function automatic logic [15:0] pick16();
        case ($urandom_range(0, 5))
            0:       return 16'h8000;
            1:       return 16'h7FFF;
            2:       return 16'hFFFF;
            3:       return 16'h0000;
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired, R8 run did not complete actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stimulus
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; issue = 1'b0; func = 4'b0; src_sel = 1'b0; dst_sel = 1'b0;
        x_opnd = '0; y_opnd = '0;
        m_a0 = '0; m_a1 = '0; m_p = '0; m_fl = '0;
        repeat (3) @(negedge clk);
        check({acc0, acc1} == 72'd0, "R1", 64'(acc0 | acc1), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(prod == 32'd0 && {flag_neg, flag_zero, flag_ovf, flag_carry} == 4'd0,
              "R1", 64'({prod, flag_neg, flag_zero, flag_ovf, flag_carry}), 64'd0);

        // Directed: overflow by repeated accumulation of the largest product (R10).
        apply(1'b1, 4'b0010, 1'b0, 1'b0, 16'h8000, 16'h8000);
        for (int i = 0; i < 33; i++) apply(1'b1, 4'b0001, 1'b0, 1'b0, 16'h8000, 16'h8000);
        check(flag_ovf == 1'b1 || m_fl[1] == 1'b0, "R10", 64'(flag_ovf), 64'(m_fl[1]));
        // Directed: borrow on 0 - 1 (R10) and zero compare (R7).
        apply(1'b1, 4'b1100, 1'b0, 1'b1, 16'h0, 16'h0000);
        apply(1'b1, 4'b1111, 1'b1, 1'b1, 16'h0, 16'h0001);
        check(flag_carry == 1'b1, "R10", 64'(flag_carry), 64'd1);
        apply(1'b1, 4'b1011, 1'b1, 1'b0, 16'h0, 16'hFFFF);
        check(flag_zero == 1'b1, "R7", 64'(flag_zero), 64'd1);
        // Directed: multiply-only keeps flags, nop and idle change nothing (R11, R8).
        apply(1'b1, 4'b0010, 1'b0, 1'b0, 16'h1234, 16'h8000);
        apply(1'b1, 4'b0110, 1'b1, 1'b1, 16'h7FFF, 16'h7FFF);
        apply(1'b0, 4'b1100, 1'b0, 1'b0, 16'h5555, 16'h5555);
        // Back-to-back product pipeline with changing operands (R3).
        for (int i = 0; i < 200; i++)
            apply(1'b1, 4'({$urandom_range(0, 1), 1'b0, $urandom_range(0, 1)} == 3'b010
                           ? 4'b0011 : {2'b00, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1))}),
                  1'($urandom), 1'($urandom), pick16(), pick16());
        // Constrained random mix.
        for (int i = 0; i < 3000; i++)
            apply(($urandom_range(0, 9) != 0), 4'($urandom), 1'($urandom), 1'($urandom),
                  pick16(), pick16());
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule